// File: doc/BRIEF.md
# Serial Configuration Memory Read Controller

This block is the read side of a serial configuration memory. A byte-wide storage array holds a bitstream, and the block sends it one bit per clock to an FPGA that loads itself in master serial mode. The FPGA drives the block's clock and its two control pins. These are an active-low chip select and a combined control pin. One level of the control pin resets the read position and the other level enables the output. A parameter selects which level does which. A mode input chooses between read mode and programming mode.

Inside the block, a bit counter moves through each byte with the most significant bit first. A byte address counter steps to the next location when the bit counter wraps, and it returns to zero after the last location. The serial output is modelled as a data bit plus an output-enable flag, and the data bit is held at 0 whenever the flag is low.

In programming mode a valid/ready write port loads the array, one byte per accepted cycle. `wr_ready` is high only in programming mode. A write takes place on a rising edge when `wr_valid` and `wr_ready` are both high. An offer made while `wr_ready` is low is not taken: nothing is written, and the writer may keep the offer up or withdraw it. The serial output has no back-pressure, because the loading FPGA paces it through the clock.

Top module: `cfgmem_reader`

## Requirements
- R1: In read mode, when `ctl_pin` is at its reset level, `dout_oe` is low and the next rising edge sets the read position to address 0, bit 7, whatever the level of `chip_en_n`.
- R2: With `RESET_LOW`=1 (the default), `ctl_pin`=0 is the reset level and `ctl_pin`=1 is the enable level. With `RESET_LOW`=0, the two levels are swapped.
- R3: `dout_oe` is high exactly when `read_mode`=1, `chip_en_n`=0 and `ctl_pin` is at its enable level. Each rising edge in that state advances the read position by one bit. When `dout_oe` is low, `dout` is 0.
- R4: `dout` shows bit (7 − b) of the byte at address a, where b (0..7) and a are the current bit and address counts. After the eighth bit, the next byte follows.
- R5: After bit 0 of address `DEPTH`−1 is sent, the stream continues at bit 7 of address 0.
- R6: In read mode with `chip_en_n`=1, `standby` is high, `dout_oe` is low and the read position holds. Output resumes at the held bit once `chip_en_n` returns low.
- R7: While `rst_n` is low, each rising edge sets the read position to address 0, bit 7.
- R8: With `read_mode`=0, `dout_oe` and `standby` are low whatever the level of `chip_en_n`, and the read position is held at address 0, bit 7.
- R9: `wr_ready` equals the inverse of `read_mode`. A write happens only on a rising edge with `wr_valid` and `wr_ready` both high, and it stores `wr_data` at `wr_addr`.
- R10: If `chip_en_n` stays high after a reset pulse on `ctl_pin`, no bit is consumed. The first bit sent after `chip_en_n` goes low is bit 7 of address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock from the loading FPGA |
| rst_n | input | 1 | Block reset, active low, synchronous |
| chip_en_n | input | 1 | Chip select, active low |
| ctl_pin | input | 1 | Combined reset / output-enable pin, polarity set by `RESET_LOW` |
| read_mode | input | 1 | 1 = configuration read mode, 0 = programming mode |
| wr_valid | input | 1 | Test write offer |
| wr_ready | output | 1 | Write port can accept (programming mode) |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Byte to store |
| dout | output | 1 | Serial data bit, 0 when not driven |
| dout_oe | output | 1 | Serial output driver enable |
| standby | output | 1 | Low-power standby indication |

## Verification
The bench builds two copies with `DEPTH`=16, a shallow array. With that depth, the wrap from the last address back to zero falls inside a run of about 140 clocks, and every location can be loaded and compared. One copy keeps the default `RESET_LOW`=1 and carries all the stream scenarios. The second copy uses `RESET_LOW`=0 and shares the write port, so the swapped pin polarity is checked against the same array contents.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W);

  typedef struct packed {
    logic clear;    // force read position to start
    logic advance;  // step one bit this edge
    logic drive;    // serial output driver on
    logic standby;  // chip deselected in read mode
    logic prog;     // programming mode
  } pin_state_t;
endpackage

// File: rtl/cfgmem_pin_decode.sv
module cfgmem_pin_decode
  import cfgmem_pkg::*;
#(
  parameter bit RESET_LOW = 1'b1
) (
  input  logic       chip_en_n,
  input  logic       ctl_pin,
  input  logic       read_mode,
  output pin_state_t st
);
  localparam logic RESET_LEVEL = RESET_LOW ? 1'b0 : 1'b1;

  logic reset_seen;

  always_comb begin
    reset_seen = (ctl_pin == RESET_LEVEL);
    st.prog    = !read_mode;
    // reset level overrides chip select; programming mode parks the counters
    st.clear   = read_mode ? reset_seen : 1'b1;
    st.standby = read_mode && chip_en_n;
    st.drive   = read_mode && !chip_en_n && !reset_seen;
    st.advance = st.drive;
  end
endmodule

// File: rtl/cfgmem_seq_counter.sv
module cfgmem_seq_counter
  import cfgmem_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  output logic [$clog2(DEPTH)-1:0] addr_q,
  output logic [BIT_W-1:0]  bit_q
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BYTE_W - 1);

  logic [ADDR_W-1:0] addr_d;
  logic [BIT_W-1:0]  bit_d;
  logic              byte_end;

  always_comb begin
    addr_d   = addr_q;
    bit_d    = bit_q;
    byte_end = (bit_q == LAST_BIT);
    if (clear) begin
      addr_d = '0;
      bit_d  = '0;
    end else if (advance) begin
      bit_d = byte_end ? '0 : bit_q + 1'b1;
      if (byte_end) addr_d = (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      bit_q  <= '0;
    end else begin
      addr_q <= addr_d;
      bit_q  <= bit_d;
    end
  end

  AST_CLEAR_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (addr_q == '0 && bit_q == '0)); // R1
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !advance) |=> ($stable(addr_q) && $stable(bit_q))); // R6
  AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && advance) |=> (bit_q == BIT_W'($past(bit_q) + 1'b1))); // R3
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && advance && bit_q == LAST_BIT && addr_q == LAST_ADDR) |=> (addr_q == '0)); // R5
endmodule

// File: rtl/cfgmem_array.sv
module cfgmem_array
  import cfgmem_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     wr_fire,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [BYTE_W-1:0]        wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [BYTE_W-1:0]        rd_byte
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_addr] <= wr_data;
  end

  assign rd_byte = mem[rd_addr];
endmodule

// File: rtl/cfgmem_reader.sv
module cfgmem_reader
  import cfgmem_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter bit RESET_LOW = 1'b1,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en_n,
  input  logic              ctl_pin,
  input  logic              read_mode,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              dout,
  output logic              dout_oe,
  output logic              standby
);
  localparam logic RESET_LEVEL = RESET_LOW ? 1'b0 : 1'b1;
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(BYTE_W - 1);

  pin_state_t        st;
  logic [ADDR_W-1:0] rd_addr;
  logic [BIT_W-1:0]  bit_pos;
  logic [BYTE_W-1:0] rd_byte;

  cfgmem_pin_decode #(.RESET_LOW(RESET_LOW)) u_decode (
    .chip_en_n (chip_en_n),
    .ctl_pin   (ctl_pin),
    .read_mode (read_mode),
    .st        (st)
  );

  cfgmem_seq_counter #(.DEPTH(DEPTH)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (st.clear),
    .advance (st.advance),
    .addr_q  (rd_addr),
    .bit_q   (bit_pos)
  );

  cfgmem_array #(.DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .wr_fire (wr_valid && wr_ready),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_byte (rd_byte)
  );

  assign wr_ready = st.prog;
  assign standby  = st.standby;
  assign dout_oe  = st.drive;
  assign dout     = st.drive ? rd_byte[TOP_BIT - bit_pos] : 1'b0;

  AST_RESET_BEATS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (read_mode && ctl_pin == RESET_LEVEL) |-> !dout_oe); // R1
  AST_DRIVE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (read_mode && !chip_en_n)); // R3
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> !dout); // R3
  AST_STANDBY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (read_mode && chip_en_n) |-> (standby && !dout_oe)); // R6
  AST_PROG_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !read_mode |-> (!dout_oe && !standby && wr_ready)); // R8
endmodule

// File: tb/cfgmem_reader_test.sv
module cfgmem_reader_test;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, chip_en_n, ctl_pin, ctl_pin_b, read_mode, wr_valid;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic wr_ready, dout, dout_oe, standby;
  logic wr_ready_b, dout_b, dout_oe_b, standby_b;

  int total = 0;
  int bad   = 0;
  logic [7:0] model [DEPTH];
  int exp_addr, exp_bit;

  cfgmem_reader #(.DEPTH(DEPTH), .RESET_LOW(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .ctl_pin(ctl_pin),
    .read_mode(read_mode), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .dout(dout), .dout_oe(dout_oe),
    .standby(standby));

  cfgmem_reader #(.DEPTH(DEPTH), .RESET_LOW(1'b0)) uut_pol (
    .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .ctl_pin(ctl_pin_b),
    .read_mode(read_mode), .wr_valid(wr_valid), .wr_ready(wr_ready_b),
    .wr_addr(wr_addr), .wr_data(wr_data), .dout(dout_b), .dout_oe(dout_oe_b),
    .standby(standby_b));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic read_stream(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      check(req, "dout_oe", dout_oe, 1);
      check(req, "dout", dout, model[exp_addr][7-exp_bit]);
      step();
      if (exp_bit == 7) begin
        exp_bit  = 0;
        exp_addr = (exp_addr == DEPTH-1) ? 0 : exp_addr + 1;
      end else exp_bit++;
    end
  endtask

  task automatic ctl_reset_pulse();
    ctl_pin = 1'b0; step(); ctl_pin = 1'b1;
    exp_addr = 0; exp_bit = 0;
  endtask

  task automatic t_reset_state();
    check("R7", "dout_oe in reset", dout_oe, 0);
    check("R7", "standby in reset", standby, 1);
    check("R9", "wr_ready read mode", wr_ready, 0);
    rst_n = 1'b1; step();
  endtask

  task automatic t_load();
    read_mode = 1'b0; chip_en_n = 1'b0; ctl_pin = 1'b1; #1;
    check("R8", "dout_oe prog mode", dout_oe, 0);
    check("R8", "standby prog mode", standby, 0);
    check("R9", "wr_ready prog mode", wr_ready, 1);
    for (int i = 0; i < DEPTH; i++) begin
      model[i]  = 8'(8'hA5 ^ (i * 37));
      wr_valid  = 1'b1; wr_addr = AW'(i); wr_data = model[i];
      step();
    end
    wr_valid = 1'b0;
  endtask

  task automatic t_stream();
    read_mode = 1'b1; chip_en_n = 1'b0; ctl_pin = 1'b0; #1;
    check("R1", "dout_oe at reset level", dout_oe, 0);
    step(); ctl_pin = 1'b1; exp_addr = 0; exp_bit = 0; #1;
    read_stream(DEPTH*8 + 12, "R3 R4 R5");
  endtask

  task automatic t_freeze();
    chip_en_n = 1'b1; #1;
    check("R6", "dout_oe deselected", dout_oe, 0);
    check("R6", "standby deselected", standby, 1);
    check("R3", "dout when off", dout, 0);
    repeat (3) step();
    chip_en_n = 1'b0; #1;
    read_stream(10, "R6");
  endtask

  task automatic t_reset_override();
    chip_en_n = 1'b0; ctl_pin = 1'b0; #1;
    check("R1", "dout_oe reset with select low", dout_oe, 0);
    repeat (2) step();
    ctl_pin = 1'b1; exp_addr = 0; exp_bit = 0; #1;
    read_stream(9, "R1");
  endtask

  task automatic t_ce_after_reset();
    chip_en_n = 1'b1; ctl_pin_b = 1'b1;
    ctl_reset_pulse();
    repeat (4) begin
      check("R10", "dout_oe held off", dout_oe, 0);
      step();
    end
    chip_en_n = 1'b0; #1;
    read_stream(9, "R10");
  endtask

  task automatic t_prog_clear();
    read_mode = 1'b0; #1;
    check("R8", "dout_oe prog select low", dout_oe, 0);
    check("R8", "standby prog", standby, 0);
    step();
    read_mode = 1'b1; exp_addr = 0; exp_bit = 0; #1;
    read_stream(9, "R8");
  endtask

  task automatic t_block_reset();
    rst_n = 1'b0; step();
    rst_n = 1'b1; exp_addr = 0; exp_bit = 0; #1;
    read_stream(9, "R7");
  endtask

  task automatic t_write_ignored();
    wr_valid = 1'b1; wr_addr = '0; wr_data = ~model[0]; #1;
    check("R9", "wr_ready in read mode", wr_ready, 0);
    repeat (2) step();
    wr_valid = 1'b0;
    ctl_reset_pulse(); #1;
    read_stream(8, "R9");
  endtask

  task automatic t_polarity();
    chip_en_n = 1'b0; ctl_pin = 1'b1; ctl_pin_b = 1'b1; #1;
    check("R2", "default: high level enables", dout_oe, 1);
    check("R2", "swapped: high level resets", dout_oe_b, 0);
    step();
    ctl_pin_b = 1'b0; #1;
    check("R2", "swapped: low level enables", dout_oe_b, 1);
    check("R2", "swapped first bit", dout_b, model[0][7]);
    step();
    check("R2", "swapped second bit", dout_b, model[0][6]);
    ctl_pin_b = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; read_mode = 1'b1; chip_en_n = 1'b1; ctl_pin = 1'b1;
    ctl_pin_b = 1'b1; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    exp_addr = 0; exp_bit = 0;
    repeat (3) step();
    t_reset_state();
    t_load();
    t_stream();
    t_freeze();
    t_reset_override();
    read_stream(5, "R4");
    t_ce_after_reset();
    read_stream(3, "R4");
    t_prog_clear();
    read_stream(4, "R4");
    t_block_reset();
    t_write_ignored();
    t_polarity();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule